// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits beside an instruction fetch unit and keeps, for each recently seen control-transfer destination, the first four instruction words found there. Every time the fetch unit changes its flow (taken branch, jump, call, return, exception vector entry, or straight-line fetch that steps over a page boundary), it presents the new fetch address. On a hit the block returns the four stored words one cycle later. In the same cycle it issues an external memory request for the word just after them, so the memory latency is hidden behind the cached words.

On a miss the block requests the destination address itself and raises a stall. The stall is released as soon as the first word comes back, not when the whole line is in. The returning words are written into the chosen entry one at a time. The entry is marked usable only when the last of the four has arrived. A new redirect that arrives while a line is still filling abandons that fill, unless it points at the very line being filled. In that case it is reported as a miss and the fill carries on.

Saturating counters record how many redirect lookups hit and how many missed. A small read/clear port gives access to them.

Top module: `tgt_icache`

## Requirements
- R1: Each `redir_valid` pulse, whatever its `redir_kind` code (0 conditional, 1 jump, 2 call, 3 return, 4 vector, 5 page crossing), produces exactly one `rsp_valid` pulse in the following cycle, with `rsp_kind` echoing the code.
- R2: On a hit, `rsp_hit` is 1 and `rsp_data` slice i (bits i*32+31 down to i*32) holds the word at word address target+i. In the same cycle, `mem_req_valid` is 1 and `mem_req_addr` is target+4.
- R3: On a miss that allocates, `rsp_hit` is 0 and `mem_req_addr` is the target. `stall` is 1 in the response cycle and falls in the cycle after the first `mem_rvalid` word is taken.
- R4: A filling entry only becomes valid once all four words have returned. After that, a redirect to the same target hits with those words.
- R5: A redirect to another address during a fill abandons it, and a later lookup of the abandoned target misses.
- R6: A redirect to the target currently filling reports a miss, issues no memory request, and the fill completes and later hits.
- R7: The mapping is direct. The index is word-address bits [4:0] and the tag is the remaining upper bits. Two targets sharing an index evict each other.
- R8: `inv_all` invalidates every entry, abandons any fill and drops `stall` in the next cycle.
- R9: The hit and miss counters change only on redirect lookups. Memory return words do not count. A redirect to the filling line counts as a miss.
- R10: The counters saturate at their all-ones value.
- R11: `st_rdata` shows the hit counter (`st_sel`=0) or the miss counter (`st_sel`=1) one cycle after selection. `st_clr` zeroes both counters.
- R12: `mem_rvalid` words arriving while no fill is in progress change no entry and do not touch `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Redirect strobe |
| redir_addr | input | ADDR_W | Redirect word address |
| redir_kind | input | 3 | Redirect kind code |
| inv_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_kind | output | 3 | Kind code of the answered redirect |
| rsp_data | output | WORDS*DATA_W | Cached words on a hit |
| stall | output | 1 | Fetch stall during a miss |
| mem_req_valid | output | 1 | External fetch request |
| mem_req_addr | output | ADDR_W | External fetch word address |
| mem_rvalid | input | 1 | Memory return word valid |
| mem_rdata | input | DATA_W | Memory return word |
| st_sel | input | 1 | Counter select (0 hits, 1 misses) |
| st_clr | input | 1 | Clear both counters |
| st_rdata | output | CNT_W | Selected counter value |

## Verification
The lookup answer (`rsp_valid`, `rsp_hit`, `rsp_kind`, `rsp_data`) and the memory request it spawns are due exactly one clock after the redirect. The driver pushes each expected answer into a queue when it raises the strobe, and the monitor pops and compares on the next falling edge where `rsp_valid` is seen. `stall` is checked on the falling edge right after the response and again one cycle after the first return word is presented. Counter reads are sampled one full cycle after the select is driven.

// File: rtl/tgt_icache_pkg.sv
package tgt_icache_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_COND   = 3'd0,
    KIND_JUMP   = 3'd1,
    KIND_CALL   = 3'd2,
    KIND_RETURN = 3'd3,
    KIND_VECTOR = 3'd4,
    KIND_PAGE   = 3'd5
  } redir_kind_e;
endpackage

// File: rtl/tgt_icache_tags.sv
// Valid bits and tags, one per entry; combinational compare for the lookup.
module tgt_icache_tags #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5,
  parameter int TAG_W   = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (clr_en && clr_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
        end else if (set_en && set_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      tag_q[set_idx] <= set_tag;
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/tgt_icache_bank.sv
// One word lane of the line store: simple dual-port RAM, registered read.
module tgt_icache_bank #(
  parameter int DEPTH  = 32,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/tgt_icache_stats.sv
// Saturating hit/miss counters with a registered read port.
module tgt_icache_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit_inc,
  input  logic             miss_inc,
  input  logic             sel,
  output logic [CNT_W-1:0] rdata
);
  logic [CNT_W-1:0] hit_q;
  logic [CNT_W-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      if (hit_inc && hit_q != '1) begin
        hit_q <= hit_q + 1'b1;
      end
      if (miss_inc && miss_q != '1) begin
        miss_q <= miss_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= sel ? miss_q : hit_q;
    end
  end
endmodule

// File: rtl/tgt_icache.sv
module tgt_icache
  import tgt_icache_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WORDS   = 4,
  parameter int ADDR_W  = 30,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    redir_valid,
  input  logic [ADDR_W-1:0]       redir_addr,
  input  logic [KIND_W-1:0]       redir_kind,
  input  logic                    inv_all,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [KIND_W-1:0]       rsp_kind,
  output logic [WORDS*DATA_W-1:0] rsp_data,
  output logic                    stall,
  output logic                    mem_req_valid,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rvalid,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    st_sel,
  input  logic                    st_clr,
  output logic [CNT_W-1:0]        st_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [IDX_W-1:0] redir_idx;
  logic [TAG_W-1:0] redir_tag;
  logic             lk_hit;

  logic             fill_active;
  logic [CW-1:0]    fill_cnt;
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;

  logic hit_now, same_fill, alloc, fill_keep, fill_we, fill_last;

  assign redir_idx = redir_addr[IDX_W-1:0];
  assign redir_tag = redir_addr[ADDR_W-1:IDX_W];

  always_comb begin
    hit_now   = redir_valid && !inv_all && lk_hit;
    same_fill = redir_valid && !inv_all && fill_active &&
                (redir_idx == fill_idx) && (redir_tag == fill_tag);
    alloc     = redir_valid && !hit_now && !same_fill;
    fill_keep = fill_active && !inv_all && (!redir_valid || same_fill);
    fill_we   = fill_keep && mem_rvalid;
    fill_last = (fill_cnt == CW'(WORDS - 1));
  end

  tgt_icache_tags #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .inv_all (inv_all),
    .lk_idx  (redir_idx),
    .lk_tag  (redir_tag),
    .lk_hit  (lk_hit),
    .clr_en  (alloc),
    .clr_idx (redir_idx),
    .set_en  (fill_we && fill_last),
    .set_idx (fill_idx),
    .set_tag (fill_tag)
  );

  for (genvar b = 0; b < WORDS; b++) begin : g_lane
    tgt_icache_bank #(
      .DEPTH(ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_bank (
      .clk   (clk),
      .we    (fill_we && (fill_cnt == CW'(b))),
      .waddr (fill_idx),
      .wdata (mem_rdata),
      .re    (redir_valid),
      .raddr (redir_idx),
      .rdata (rsp_data[b*DATA_W +: DATA_W])
    );
  end

  tgt_icache_stats #(.CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst      (rst),
    .clr      (st_clr),
    .hit_inc  (hit_now),
    .miss_inc (redir_valid && !hit_now),
    .sel      (st_sel),
    .rdata    (st_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_kind      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      stall         <= 1'b0;
      fill_active   <= 1'b0;
      fill_cnt      <= '0;
      fill_idx      <= '0;
      fill_tag      <= '0;
    end else begin
      rsp_valid     <= redir_valid;
      rsp_hit       <= hit_now;
      mem_req_valid <= hit_now || alloc;
      if (redir_valid) begin
        rsp_kind     <= redir_kind;
        mem_req_addr <= hit_now ? redir_addr + ADDR_W'(WORDS) : redir_addr;
      end
      if (fill_we) begin
        fill_cnt <= fill_cnt + 1'b1;
        if (fill_cnt == '0) stall <= 1'b0;
        if (fill_last) fill_active <= 1'b0;
      end
      if (inv_all) begin
        fill_active <= 1'b0;
        stall       <= 1'b0;
      end
      if (alloc) begin
        fill_active <= 1'b1;
        fill_cnt    <= '0;
        fill_idx    <= redir_idx;
        fill_tag    <= redir_tag;
        stall       <= 1'b1;
      end else if (hit_now) begin
        fill_active <= 1'b0;
        stall       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tgt_icache_chk.sv
module tgt_icache_chk #(
  parameter int ADDR_W = 30,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              inv_all,
  input logic              mem_rvalid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              stall,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr
);
  // R1
  rsp_follows_redir_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> rsp_valid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !redir_valid |=> !rsp_valid);

  // R2
  hit_prefetch_next_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |->
      (mem_req_valid && mem_req_addr == $past(redir_addr) + ADDR_W'(WORDS)));

  // R3
  miss_fetch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && mem_req_valid) |->
      (mem_req_addr == $past(redir_addr) && stall));

  // R3
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && mem_rvalid && !redir_valid && !inv_all) |=> !stall);

  // R8
  inv_drops_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !redir_valid) |=> !stall);

  // R2
  req_only_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> rsp_valid);
endmodule

bind tgt_icache tgt_icache_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .redir_valid   (redir_valid),
  .redir_addr    (redir_addr),
  .inv_all       (inv_all),
  .mem_rvalid    (mem_rvalid),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .stall         (stall),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/tgt_icache_bench.sv
`timescale 1ns/1ps
module tgt_icache_bench;
  import tgt_icache_pkg::*;

  localparam int ENTRIES = 32;
  localparam int WORDS   = 4;
  localparam int ADDR_W  = 30;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rst = 1'b1;
  logic                    redir_valid = 1'b0;
  logic [ADDR_W-1:0]       redir_addr = '0;
  logic [KIND_W-1:0]       redir_kind = '0;
  logic                    inv_all = 1'b0;
  logic                    rsp_valid, rsp_hit, stall, mem_req_valid;
  logic [KIND_W-1:0]       rsp_kind;
  logic [WORDS*DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0]       mem_req_addr;
  logic                    mem_rvalid = 1'b0;
  logic [DATA_W-1:0]       mem_rdata = '0;
  logic                    st_sel = 1'b0;
  logic                    st_clr = 1'b0;
  logic [CNT_W-1:0]        st_rdata;

  tgt_icache #(
    .ENTRIES(ENTRIES), .WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_tgt_icache (
    .clk(clk), .rst(rst), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .redir_kind(redir_kind), .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_kind(rsp_kind), .rsp_data(rsp_data), .stall(stall), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .st_sel(st_sel), .st_clr(st_clr), .st_rdata(st_rdata)
  );

  typedef struct {
    bit                    hit;
    bit                    req;
    logic [ADDR_W-1:0]     req_addr;
    logic [KIND_W-1:0]     kind;
    logic [WORDS*DATA_W-1:0] data;
    string                 req_tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int exp_hits = 0;
  int exp_miss = 0;
  bit done = 1'b0;

  localparam logic [ADDR_W-1:0] A = 30'h100;
  localparam logic [ADDR_W-1:0] B = 30'h205;
  localparam logic [ADDR_W-1:0] C = 30'h3A6;
  localparam logic [ADDR_W-1:0] D = 30'h047;
  localparam logic [ADDR_W-1:0] E = 30'h120;  // same index as A
  localparam logic [ADDR_W-1:0] F = 30'h5C8;

  function automatic logic [DATA_W-1:0] mword(logic [ADDR_W-1:0] a);
    return {a, 2'b01} ^ 32'hC3C3_0000;
  endfunction

  function automatic logic [WORDS*DATA_W-1:0] mline(logic [ADDR_W-1:0] a);
    logic [WORDS*DATA_W-1:0] l;
    for (int i = 0; i < WORDS; i++) l[i*DATA_W +: DATA_W] = mword(a + ADDR_W'(i));
    return l;
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > (2**CNT_W - 1)) ? (2**CNT_W - 1) : v;
  endfunction

  // Driver: push the expected answer, then pulse the redirect for one cycle.
  task automatic redir(logic [ADDR_W-1:0] a, redir_kind_e k, bit hit, bit req, string r);
    exp_t e;
    e.hit = hit; e.req = req; e.kind = k; e.data = mline(a); e.req_tag = r;
    e.req_addr = hit ? a + ADDR_W'(WORDS) : a;
    q.push_back(e);
    if (hit) exp_hits++; else exp_miss++;
    @(negedge clk);
    redir_valid = 1'b1; redir_addr = a; redir_kind = k;
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  task automatic feed(logic [ADDR_W-1:0] base, int n);
    for (int i = 0; i < n; i++) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mword(base + ADDR_W'(i));
      @(negedge clk);
    end
    mem_rvalid = 1'b0;
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
  endtask

  task automatic read_stat(bit s, int exp, string r);
    @(negedge clk); st_sel = s;
    @(negedge clk);
    check(st_rdata == CNT_W'(exp), r, s ? "miss counter" : "hit counter", st_rdata, exp);
  endtask

  // Monitor: pop and compare on every response.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R1", "unexpected response", 1, 0);
      end else begin
        e = q.pop_front();
        check(rsp_hit == e.hit, e.req_tag, "rsp_hit", rsp_hit, e.hit);
        check(rsp_kind == e.kind, "R1", "rsp_kind", rsp_kind, e.kind);
        if (e.hit) check(rsp_data == e.data, "R2", "rsp_data", rsp_data, e.data);
        check(mem_req_valid == e.req, e.req_tag, "mem_req_valid", mem_req_valid, e.req);
        if (e.req) check(mem_req_addr == e.req_addr, e.hit ? "R2" : "R3",
                         "mem_req_addr", mem_req_addr, e.req_addr);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R1, R11)
    check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(stall == 0, "R3", "stall after reset", stall, 0);
    check(mem_req_valid == 0, "R2", "mem_req_valid after reset", mem_req_valid, 0);
    read_stat(1'b0, 0, "R11");

    // R3 miss and early stall release, R4 fill then hit
    redir(A, KIND_COND, 0, 1, "R3");
    check(stall == 1, "R3", "stall on miss", stall, 1);
    feed(A, 1);
    check(stall == 0, "R3", "stall after first word", stall, 0);
    feed(A + 1, 3);
    redir(A, KIND_PAGE, 1, 1, "R4");

    // R5 abandoned fill
    redir(B, KIND_JUMP, 0, 1, "R5");
    feed(B, 2);
    redir(C, KIND_VECTOR, 0, 1, "R5");
    feed(C, 4);
    redir(B, KIND_CALL, 0, 1, "R5");
    feed(B, 4);
    redir(C, KIND_RETURN, 1, 1, "R4");
    redir(B, KIND_COND, 1, 1, "R4");

    // R6 redirect to the line being filled
    redir(D, KIND_COND, 0, 1, "R6");
    feed(D, 3);
    redir(D, KIND_RETURN, 0, 0, "R6");
    check(stall == 0, "R6", "stall on same-line miss", stall, 0);
    feed(D + 3, 1);
    redir(D, KIND_JUMP, 1, 1, "R6");

    // R7 index conflict
    redir(E, KIND_COND, 0, 1, "R7");
    feed(E, 4);
    redir(A, KIND_COND, 0, 1, "R7");
    feed(A, 4);
    redir(E, KIND_CALL, 0, 1, "R7");
    feed(E, 4);
    redir(E, KIND_COND, 1, 1, "R7");

    // R12 stray return words
    feed(30'h777, 4);
    check(stall == 0, "R12", "stall after stray words", stall, 0);
    redir(E, KIND_JUMP, 1, 1, "R12");

    // R9 counters follow lookups only
    read_stat(1'b0, sat(exp_hits), "R9");
    read_stat(1'b1, sat(exp_miss), "R9");

    // R8 invalidate all, including during a fill
    pulse_inv();
    redir(E, KIND_COND, 0, 1, "R8");
    feed(E, 4);
    redir(F, KIND_COND, 0, 1, "R8");
    check(stall == 1, "R8", "stall before invalidate", stall, 1);
    pulse_inv();
    check(stall == 0, "R8", "stall after invalidate", stall, 0);
    feed(F, 4);
    redir(F, KIND_VECTOR, 0, 1, "R8");
    feed(F, 4);
    redir(F, KIND_COND, 1, 1, "R8");

    // R11 clear
    @(negedge clk); st_clr = 1'b1;
    @(negedge clk); st_clr = 1'b0;
    exp_hits = 0; exp_miss = 0;
    read_stat(1'b0, 0, "R11");
    read_stat(1'b1, 0, "R11");

    // R10 saturation
    for (int i = 0; i < 18; i++) redir(F, KIND_JUMP, 1, 1, "R10");
    read_stat(1'b0, sat(exp_hits), "R10");
    read_stat(1'b1, 0, "R10");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R1", "responses outstanding", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule